// File: doc/BRIEF.md
# Message-Out Sequencer for a REQ/ACK Parallel Bus

This block is the initiator-side engine that delivers a multi-byte message to a target over a parallel bus that moves one byte per REQ/ACK handshake. Before data is queued, the host writes the message length into a transfer-size register. The host then pushes the message bytes into a local byte FIFO and pulses a start strobe. The engine raises ATN for the whole message. It watches REQ and the three phase lines. It places each byte on the data lines and handshakes it with ACK.

The handshake waits whenever the FIFO runs dry. A request arriving in the wrong phase stops the command and flags an error. A completed message drops ATN, sets a GOOD status bit and raises the interrupt. Both status bits are sticky until the host clears them by writing ones.

Top module: `msgout_seq`

## Requirements
- R1: After reset, `bus_ack_o`, `bus_atn_o`, `busy_o`, `good_o`, `phase_err_o` and `irq_o` are all low.
- R2: A `start` pulse taken in while idle with a non-zero size asserts ATN and keeps ACK low from the next clock edge, with `busy_o` high.
- R3: A byte is sent only for a REQ seen with the message-out phase {MSG,C/D,I/O} = 3'b110. The byte is on `bus_data_o` one cycle before ACK rises and stays unchanged while ACK is high.
- R4: ACK stays high until the target drops REQ and is released on the next edge. Bytes leave in FIFO write order, one per handshake.
- R5: If the FIFO is empty when REQ arrives in the message-out phase, ACK stays low until a byte is written.
- R6: ATN stays high between bytes of one message. It falls on the same edge that releases ACK for the last programmed byte.
- R7: Completion sets `good_o` (clear bit 0) and `irq_o` on that same edge. Both stay set until a clear write with bit 0 set.
- R8: A REQ whose phase is not 3'b110 ends the command on the next edge. ATN drops, `phase_err_o` (clear bit 1) and `irq_o` rise, no ACK is given, and the pending byte stays in the FIFO.
- R9: A `start` with the size register at zero sets `good_o` on the next edge and never asserts ATN.
- R10: `fifo_full_o` is high when FIFO_DEPTH bytes are held, and a write while full is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| size_we | input | 1 | Write strobe for the transfer-size register |
| size_data | input | CNT_W | Message length in bytes |
| fifo_we | input | 1 | Push one byte into the message FIFO |
| fifo_wdata | input | DATA_W | Byte to push |
| fifo_full_o | output | 1 | FIFO holds FIFO_DEPTH bytes |
| start | input | 1 | Command launch strobe |
| clr_we | input | 1 | Status clear strobe |
| clr_data | input | 2 | Bits to clear: bit 0 GOOD, bit 1 phase error |
| bus_req_i | input | 1 | Target request (active high) |
| bus_msg_i | input | 1 | MSG phase line |
| bus_cd_i | input | 1 | C/D phase line |
| bus_io_i | input | 1 | I/O phase line |
| bus_ack_o | output | 1 | Initiator acknowledge (active high) |
| bus_atn_o | output | 1 | Attention (active high) |
| bus_data_o | output | DATA_W | Byte driven to the bus |
| busy_o | output | 1 | Command in progress |
| good_o | output | 1 | Sticky completion status |
| phase_err_o | output | 1 | Sticky phase error status |
| irq_o | output | 1 | Interrupt, high while any status bit is set |

## Verification
The bench builds the block with FIFO_DEPTH = 4 and CNT_W = 5. With a four-entry FIFO, the full flag and a discarded fifth write can be reached in a few cycles. A later one-byte command then shows the dropped byte is absent: the engine stalls instead of sending it. The small depth also lets a second command run after a phase error and show that the rejected byte is still first in line. The five-bit size register covers all message lengths used, including zero.

// File: rtl/msgout_pkg.sv
package msgout_pkg;

  // handshake engine states
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_LOAD,
    ST_ASSERT,
    ST_HOLD
  } hs_state_e;

  // phase lines packed as {msg, cd, io}
  localparam logic [2:0] PH_MSG_OUT = 3'b110;

  // one-cycle status events from the engine
  typedef struct packed {
    logic done;
    logic phase_err;
  } hs_event_t;

endpackage

// File: rtl/msgout_fifo.sv
module msgout_fifo #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              empty,
  output logic              full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW:0] wptr, rptr;
  logic wr_ok;

  assign empty = (wptr == rptr);
  assign full  = (wptr[AW] != rptr[AW]) && (wptr[AW-1:0] == rptr[AW-1:0]);
  assign wr_ok = wr_en && !full;

  // storage without reset so a block RAM can be inferred
  always_ff @(posedge clk) begin
    if (wr_ok) mem[wptr[AW-1:0]] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rd_en) rd_data <= mem[rptr[AW-1:0]];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr <= '0;
      rptr <= '0;
    end else begin
      if (wr_ok) wptr <= wptr + 1'b1;
      if (rd_en) rptr <= rptr + 1'b1;
    end
  end

  // the engine must never pop an empty FIFO
  a_r10_no_pop_empty: assert property (@(posedge clk) disable iff (rst)
    rd_en |-> !empty);

  // a write while full leaves the write pointer unchanged
  a_r10_full_drops: assert property (@(posedge clk) disable iff (rst)
    (wr_en && full && !rd_en) |=> $stable(wptr));

endmodule

// File: rtl/msgout_bytecnt.sv
module msgout_bytecnt #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  output logic             last
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (load) cnt <= load_val;
    else if (dec)  cnt <= cnt - 1'b1;
  end

  assign last = (cnt == {{(CNT_W-1){1'b0}}, 1'b1});

  // R4: each released handshake consumes one remaining byte
  a_r4_dec_nonzero: assert property (@(posedge clk) disable iff (rst)
    dec |-> (cnt != '0));

endmodule

// File: rtl/msgout_hs_fsm.sv
module msgout_hs_fsm
  import msgout_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              size_zero,
  input  logic              req,
  input  logic [2:0]        phase,
  input  logic              fifo_empty,
  input  logic [DATA_W-1:0] fifo_rdata,
  input  logic              cnt_last,
  output logic              fifo_rd,
  output logic              cnt_load,
  output logic              cnt_dec,
  output logic              ack_o,
  output logic              atn_o,
  output logic [DATA_W-1:0] data_o,
  output logic              busy_o,
  output hs_event_t         ev
);
  hs_state_e st, st_n;
  logic phase_ok;

  assign phase_ok = (phase == PH_MSG_OUT);

  always_comb begin
    st_n         = st;
    fifo_rd      = 1'b0;
    cnt_load     = 1'b0;
    cnt_dec      = 1'b0;
    ev.done      = 1'b0;
    ev.phase_err = 1'b0;
    unique case (st)
      ST_IDLE: begin
        if (start) begin
          if (size_zero) begin
            ev.done = 1'b1;
          end else begin
            cnt_load = 1'b1;
            st_n     = ST_WAIT;
          end
        end
      end
      ST_WAIT: begin
        if (req) begin
          if (!phase_ok) begin
            ev.phase_err = 1'b1;
            st_n         = ST_IDLE;
          end else if (!fifo_empty) begin
            fifo_rd = 1'b1;
            st_n    = ST_LOAD;
          end
        end
      end
      ST_LOAD:   st_n = ST_ASSERT;
      ST_ASSERT: st_n = ST_HOLD;
      ST_HOLD: begin
        if (!req) begin
          cnt_dec = 1'b1;
          if (cnt_last) begin
            ev.done = 1'b1;
            st_n    = ST_IDLE;
          end else begin
            st_n = ST_WAIT;
          end
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_IDLE;
      ack_o  <= 1'b0;
      atn_o  <= 1'b0;
      data_o <= '0;
      busy_o <= 1'b0;
    end else begin
      st     <= st_n;
      busy_o <= (st_n != ST_IDLE);
      if (cnt_load) begin
        atn_o <= 1'b1;
        ack_o <= 1'b0;
      end
      if (st == ST_LOAD)   data_o <= fifo_rdata;
      if (st == ST_ASSERT) ack_o  <= 1'b1;
      if (cnt_dec)         ack_o  <= 1'b0;
      if (ev.done || ev.phase_err) atn_o <= 1'b0;
    end
  end

  // R6: ACK is only given inside an ATN window
  a_r6_ack_under_atn: assert property (@(posedge clk) disable iff (rst)
    ack_o |-> atn_o);

  // R3: byte on the bus does not move while ACK is high
  a_r3_data_stable: assert property (@(posedge clk) disable iff (rst)
    ack_o |-> $stable(data_o));

  // R5: empty FIFO keeps ACK low
  a_r5_stall_no_ack: assert property (@(posedge clk) disable iff (rst)
    (st == ST_WAIT && fifo_empty) |=> !ack_o);

  // R8: wrong phase drops ATN and gives no ACK
  a_r8_err_stops: assert property (@(posedge clk) disable iff (rst)
    ev.phase_err |=> (!atn_o && !ack_o && !busy_o));

  // R4: ACK is released only after REQ has gone low
  a_r4_ack_release: assert property (@(posedge clk) disable iff (rst)
    $fell(ack_o) |-> !$past(req));

endmodule

// File: rtl/msgout_seq.sv
module msgout_seq
  import msgout_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int FIFO_DEPTH = 16,
  parameter int CNT_W      = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              size_we,
  input  logic [CNT_W-1:0]  size_data,
  input  logic              fifo_we,
  input  logic [DATA_W-1:0] fifo_wdata,
  output logic              fifo_full_o,
  input  logic              start,
  input  logic              clr_we,
  input  logic [1:0]        clr_data,
  input  logic              bus_req_i,
  input  logic              bus_msg_i,
  input  logic              bus_cd_i,
  input  logic              bus_io_i,
  output logic              bus_ack_o,
  output logic              bus_atn_o,
  output logic [DATA_W-1:0] bus_data_o,
  output logic              busy_o,
  output logic              good_o,
  output logic              phase_err_o,
  output logic              irq_o
);
  logic [CNT_W-1:0]  size_q;
  logic              fifo_rd, fifo_empty;
  logic [DATA_W-1:0] fifo_rdata;
  logic              cnt_load, cnt_dec, cnt_last;
  hs_event_t         ev;
  logic              good_n, perr_n;

  always_ff @(posedge clk) begin
    if (rst)          size_q <= '0;
    else if (size_we) size_q <= size_data;
  end

  msgout_fifo #(.DATA_W(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (fifo_we),
    .wr_data (fifo_wdata),
    .rd_en   (fifo_rd),
    .rd_data (fifo_rdata),
    .empty   (fifo_empty),
    .full    (fifo_full_o)
  );

  msgout_bytecnt #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .load     (cnt_load),
    .load_val (size_q),
    .dec      (cnt_dec),
    .last     (cnt_last)
  );

  msgout_hs_fsm #(.DATA_W(DATA_W)) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .size_zero  (size_q == '0),
    .req        (bus_req_i),
    .phase      ({bus_msg_i, bus_cd_i, bus_io_i}),
    .fifo_empty (fifo_empty),
    .fifo_rdata (fifo_rdata),
    .cnt_last   (cnt_last),
    .fifo_rd    (fifo_rd),
    .cnt_load   (cnt_load),
    .cnt_dec    (cnt_dec),
    .ack_o      (bus_ack_o),
    .atn_o      (bus_atn_o),
    .data_o     (bus_data_o),
    .busy_o     (busy_o),
    .ev         (ev)
  );

  // sticky status, set wins over a same-cycle clear
  always_comb begin
    good_n = (good_o      && !(clr_we && clr_data[0])) || ev.done;
    perr_n = (phase_err_o && !(clr_we && clr_data[1])) || ev.phase_err;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      good_o      <= 1'b0;
      phase_err_o <= 1'b0;
      irq_o       <= 1'b0;
    end else begin
      good_o      <= good_n;
      phase_err_o <= perr_n;
      irq_o       <= good_n || perr_n;
    end
  end

  // R7: GOOD holds until written with a one
  a_r7_good_sticky: assert property (@(posedge clk) disable iff (rst)
    (good_o && !(clr_we && clr_data[0])) |=> good_o);

  // R7: GOOD rises together with ATN falling and the interrupt
  a_r7_good_irq: assert property (@(posedge clk) disable iff (rst)
    $rose(good_o) |-> (irq_o && !bus_atn_o));

endmodule

// File: tb/msgout_seq_test.sv
module msgout_seq_test;
  localparam int DW = 8;
  localparam int DEPTH = 4;
  localparam int CW = 5;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst = 1'b1;
  logic size_we = 0, fifo_we = 0, start = 0, clr_we = 0;
  logic [CW-1:0] size_data = '0;
  logic [DW-1:0] fifo_wdata = '0;
  logic [1:0] clr_data = '0;
  logic req = 0;
  logic [2:0] ph = 3'b000;
  logic full, ack, atn, busy, good, perr, irq;
  logic [DW-1:0] data;

  msgout_seq #(.DATA_W(DW), .FIFO_DEPTH(DEPTH), .CNT_W(CW)) uut (
    .clk(clk), .rst(rst), .size_we(size_we), .size_data(size_data),
    .fifo_we(fifo_we), .fifo_wdata(fifo_wdata), .fifo_full_o(full),
    .start(start), .clr_we(clr_we), .clr_data(clr_data),
    .bus_req_i(req), .bus_msg_i(ph[2]), .bus_cd_i(ph[1]), .bus_io_i(ph[0]),
    .bus_ack_o(ack), .bus_atn_o(atn), .bus_data_o(data),
    .busy_o(busy), .good_o(good), .phase_err_o(perr), .irq_o(irq)
  );

  int checks = 0;
  int errors = 0;
  int occ = 0;
  logic [DW-1:0] exp_q[$];

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  // scoreboard monitor: compares each byte as ACK rises
  logic prev_ack = 1'b0;
  logic [DW-1:0] prev_data = '0;
  logic [DW-1:0] held = '0;
  logic [DW-1:0] e;
  always @(negedge clk) begin
    if (!rst) begin
      if (ack && !prev_ack) begin
        chk(data == prev_data, "R3 byte set up before ACK", data, prev_data);
        chk(ph == 3'b110, "R3 ACK only in message-out phase", ph, 6);
        if (exp_q.size() == 0) begin
          chk(0, "R4 unexpected byte", data, -1);
        end else begin
          e = exp_q.pop_front();
          chk(data == e, "R4 byte order", data, e);
        end
        held = data;
      end else if (ack && prev_ack && data != held) begin
        chk(0, "R3 data stable under ACK", data, held);
      end
    end
    prev_ack = ack;
    prev_data = data;
  end

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(0, "watchdog expired", 0, 1);
    summary();
    $finish;
  end

  task automatic push(input logic [DW-1:0] b);
    @(negedge clk);
    fifo_we = 1; fifo_wdata = b;
    @(negedge clk);
    fifo_we = 0;
    if (occ < DEPTH) begin
      exp_q.push_back(b);
      occ++;
    end
  endtask

  task automatic set_size(input int n);
    @(negedge clk);
    size_we = 1; size_data = CW'(n);
    @(negedge clk);
    size_we = 0;
  endtask

  task automatic start_cmd();
    @(negedge clk);
    start = 1;
    @(negedge clk);
    start = 0;
  endtask

  task automatic clear(input logic [1:0] bits);
    @(negedge clk);
    clr_we = 1; clr_data = bits;
    @(negedge clk);
    clr_we = 0;
  endtask

  task automatic handshake();
    int n = 0;
    ph = 3'b110;
    req = 1;
    while (!ack && n < 100) begin
      @(negedge clk);
      n++;
    end
    chk(ack == 1, "R4 ACK answers REQ", ack, 1);
    occ--;
    @(negedge clk);
    chk(ack == 1, "R4 ACK held while REQ high", ack, 1);
    req = 0;
    @(negedge clk);
    chk(ack == 0, "R4 ACK released after REQ low", ack, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk({ack, atn, busy, good, perr, irq} == 6'b0, "R1 reset outputs",
        {ack, atn, busy, good, perr, irq}, 0);

    // three-byte message
    set_size(3);
    push(8'hA1); push(8'h52); push(8'hC3);
    start_cmd();
    chk(atn == 1, "R2 ATN after start", atn, 1);
    chk(ack == 0, "R2 ACK low after start", ack, 0);
    chk(busy == 1, "R2 busy after start", busy, 1);
    handshake();
    chk(atn == 1, "R6 ATN held between bytes", atn, 1);
    handshake();
    chk(atn == 1, "R6 ATN held between bytes", atn, 1);
    handshake();
    chk(atn == 0, "R6 ATN dropped after last byte", atn, 0);
    chk(good == 1, "R7 GOOD on completion", good, 1);
    chk(irq == 1, "R7 interrupt on completion", irq, 1);
    chk(busy == 0, "R7 idle after completion", busy, 0);
    repeat (3) @(negedge clk);
    chk(good == 1 && irq == 1, "R7 GOOD sticky", good, 1);
    clear(2'b10);
    chk(good == 1, "R7 wrong clear bit keeps GOOD", good, 1);
    clear(2'b01);
    chk(good == 0 && irq == 0, "R7 GOOD cleared", {good, irq}, 0);

    // stall on empty FIFO
    set_size(2);
    start_cmd();
    ph = 3'b110; req = 1;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      chk(ack == 0, "R5 no ACK while FIFO empty", ack, 0);
    end
    push(8'h55);
    handshake();
    push(8'h66);
    handshake();
    chk(good == 1 && atn == 0, "R5 stalled message completes", good, 1);
    clear(2'b01);

    // wrong phase
    set_size(1);
    push(8'h77);
    start_cmd();
    ph = 3'b011; req = 1;
    @(negedge clk);
    chk(perr == 1, "R8 phase error flag", perr, 1);
    chk(irq == 1, "R8 interrupt on phase error", irq, 1);
    chk(atn == 0 && ack == 0, "R8 ATN dropped, no ACK", {atn, ack}, 0);
    chk(good == 0, "R8 no GOOD on error", good, 0);
    req = 0;
    repeat (3) begin
      @(negedge clk);
      chk(ack == 0, "R8 no ACK after error", ack, 0);
    end
    clear(2'b10);
    chk(perr == 0 && irq == 0, "R8 phase error cleared", {perr, irq}, 0);
    start_cmd();
    handshake();
    chk(good == 1, "R8 kept byte sent next command", good, 1);
    clear(2'b01);

    // zero-length command
    set_size(0);
    start_cmd();
    chk(good == 1 && irq == 1, "R9 zero size completes", good, 1);
    chk(atn == 0 && busy == 0, "R9 no ATN for zero size", atn, 0);
    clear(2'b01);

    // full FIFO and dropped write
    push(8'h10); push(8'h20); push(8'h30); push(8'h40);
    chk(full == 1, "R10 full at depth", full, 1);
    push(8'hEE);
    set_size(4);
    start_cmd();
    for (int i = 0; i < 4; i++) handshake();
    chk(good == 1, "R10 four-byte message done", good, 1);
    chk(full == 0, "R10 not full after drain", full, 0);
    clear(2'b01);
    set_size(1);
    start_cmd();
    ph = 3'b110; req = 1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk(ack == 0, "R10 write while full was dropped", ack, 0);
    end
    push(8'h99);
    handshake();
    chk(good == 1, "R10 final message done", good, 1);
    clear(2'b01);

    chk(exp_q.size() == 0, "R4 all expected bytes seen", exp_q.size(), 0);
    summary();
    $finish;
  end

endmodule